// File: doc/BRIEF.md
# I2C Converter Result Reader

This block is an I2C bus master that fetches 12-bit results from a converter that sits on the bus as a read-only slave. A start request opens a transaction: the master generates a START, clocks out a fixed device prefix with a three-bit selectable suffix and the read direction, and checks that the slave answers. It then clocks in two bytes per result. The first byte holds four padding bits and the top nibble of the value, and the second byte holds the low eight bits.

In single mode, the master takes one result, refuses the second byte with a NAK and closes the bus with a STOP. In streaming mode, it acknowledges every second byte and goes straight on to the next pair without a new START or address. It keeps going until a halt request turns the next low-byte acknowledge into a NAK. Each finished result appears on a parallel output with a one-cycle valid pulse. If the address is not acknowledged, a sticky error flag is raised and the bus is released.

SCL is derived from the system clock by a quarter-period divider. Both bus lines are open-drain: the outputs say when to pull a line low.

Top module: `adc_stream_reader`

## Requirements
- R1: After START, the master sends the address byte MSB first as 1,0,0,1 followed by devSel[2] devSel[1] devSel[0] and then a 1 (read). Every byte is followed by a ninth acknowledge clock.
- R2: On the ninth clock of the address byte the master releases SDA. If SDA is sampled high there, ackError goes to 1, the master generates STOP, no result is produced and busy returns to 0.
- R3: The master pulls SDA low on the acknowledge clock of the upper data byte. Result bits 11..8 are taken from bits 3..0 of that byte, which is received MSB first.
- R4: Result bits 7..0 are taken from the lower data byte, received MSB first. result is updated and resultValid is high for exactly one clock after D0 has been sampled.
- R5: In single mode (streamMode=0 at start), the master leaves SDA high (NAK) on the acknowledge clock of the lower byte, then generates STOP, and busy returns to 0.
- R6: In streaming mode, the master acknowledges the lower byte and clocks the next upper byte with no new START. Consecutive resultValid pulses are 18 SCL periods apart (72 quarter periods of the divider).
- R7: A haltReq seen while busy makes the next lower-byte acknowledge clock a NAK, followed by STOP.
- R8: With SCL high, SDA changes only to form START (falling) or STOP (rising). Input bits are sampled at the middle of the SCL high phase.
- R9: After reset and whenever idle, both lines are released (sclDriveLow=0, sdaDriveLow=0), busy=0 and resultValid=0.
- R10: ackError holds its value until the next accepted start request, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Begin a transaction (sampled while idle) |
| streamMode | input | 1 | 1 = continuous results, 0 = single result (latched at start) |
| haltReq | input | 1 | End a stream at the next lower-byte acknowledge |
| devSel | input | 3 | Low three address bits of the slave |
| sdaIn | input | 1 | Level of the SDA line |
| sclDriveLow | output | 1 | 1 = pull SCL low, 0 = release |
| sdaDriveLow | output | 1 | 1 = pull SDA low, 0 = release |
| result | output | 12 | Last received conversion value |
| resultValid | output | 1 | One-cycle pulse when result is new |
| ackError | output | 1 | Address was not acknowledged |
| busy | output | 1 | Transaction in progress |

## Verification
Single reads are run with values that have all zeros, all ones and alternating and sparse bit patterns, under different slave selects. This separates nibble placement, bit order and address suffix errors from each other. A stream of three queued values that is halted after the second shows that acknowledges continue without a repeated START, that the result spacing is correct and that the halt lands on the right acknowledge slot. An unacknowledged address followed by a normal read shows both that the error path works and that the flag is cleared by the next start.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_UPPER, ST_LOWER, ST_STOP
  } busState_t;

  typedef enum logic [1:0] {
    SDA_HOLD, SDA_REL, SDA_LOW, SDA_ADDR
  } sdaAct_t;

  // strobes from control to datapath; all idle unless a quarter tick fires
  typedef struct packed {
    logic     loadAddr;
    logic     sclSet;
    logic     sclLow;
    sdaAct_t  sdaAct;
    logic     framing;
    logic [2:0] bitIdx;
    logic     sample;
    logic     shiftIn;
    logic     emit;
  } strobe_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1001;

endpackage

// File: rtl/adc_rd_datapath.sv
module adc_rd_datapath
  import adc_rd_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [2:0]       devSel,
  input  logic             sdaIn,
  output logic             rxBit,
  output logic             sclLowReg,
  output logic             sdaLowReg,
  output logic [RES_W-1:0] result,
  output logic             resultValid
);

  logic [7:0]       addrByte;
  logic [RES_W-2:0] rxShift;
  logic             framedReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrByte    <= '0;
      rxShift     <= '0;
      rxBit       <= 1'b1;
      sclLowReg   <= 1'b0;
      sdaLowReg   <= 1'b0;
      framedReg   <= 1'b0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (stb.loadAddr) addrByte <= {DEV_PREFIX, devSel, 1'b1};
      if (stb.sclSet) sclLowReg <= stb.sclLow;
      if (stb.sdaAct != SDA_HOLD) begin
        framedReg <= stb.framing;
        case (stb.sdaAct)
          SDA_REL:  sdaLowReg <= 1'b0;
          SDA_LOW:  sdaLowReg <= 1'b1;
          SDA_ADDR: sdaLowReg <= ~addrByte[3'd7 - stb.bitIdx];
          default:  sdaLowReg <= sdaLowReg;
        endcase
      end
      if (stb.sample) rxBit <= sdaIn;
      if (stb.shiftIn) rxShift <= {rxShift[RES_W-3:0], sdaIn};
      if (stb.emit) begin
        result      <= {rxShift, sdaIn};
        resultValid <= 1'b1;
      end
    end
  end

  // R4: the valid strobe lasts one clock
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

  // R8: with SCL released across an edge, SDA moves only for START/STOP
  p_sda_moves_framed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclLowReg && !$past(sclLowReg) && (sdaLowReg != $past(sdaLowReg))) |-> framedReg);

endmodule

// File: rtl/adc_rd_control.sv
module adc_rd_control
  import adc_rd_pkg::*;
#(
  parameter int QTR = 31
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    startReq,
  input  logic    streamMode,
  input  logic    haltReq,
  input  logic    rxBit,
  output strobe_t stb,
  output logic    busy,
  output logic    ackError
);

  localparam int         DIV_W    = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [3:0] LAST_BIT = 4'd8;

  busState_t  state, nState;
  logic [1:0] phase, nPhase;
  logic [3:0] bitCnt, nBit;
  logic [DIV_W-1:0] divCnt;
  logic tick, isBit;
  logic streamReg, haltPend, moreReg, errReg;
  logic setErr, decideMore, moreVal;

  assign tick     = (state != ST_IDLE) && (divCnt == DIV_W'(QTR - 1));
  assign busy     = (state != ST_IDLE);
  assign ackError = errReg;

  always_comb begin
    nState     = state;
    nPhase     = phase + 2'd1;
    nBit       = bitCnt;
    setErr     = 1'b0;
    decideMore = 1'b0;
    moreVal    = 1'b0;
    stb.loadAddr = 1'b0;
    stb.sclSet   = 1'b0;
    stb.sclLow   = 1'b0;
    stb.sdaAct   = SDA_HOLD;
    stb.framing  = 1'b0;
    stb.sample   = 1'b0;
    stb.shiftIn  = 1'b0;
    stb.emit     = 1'b0;
    if (state == ST_IDLE) begin
      nPhase = 2'd0;
      nBit   = 4'd0;
      if (startReq) begin
        nState       = ST_START;
        stb.loadAddr = 1'b1;
      end
    end else if (tick) begin
      if (phase == 2'd3) begin
        nBit = bitCnt + 4'd1;
        case (state)
          ST_START: begin nState = ST_ADDR; nBit = 4'd0; end
          ST_ADDR: if (bitCnt == LAST_BIT) begin
            nBit = 4'd0;
            if (rxBit) begin nState = ST_STOP; setErr = 1'b1; end
            else nState = ST_UPPER;
          end
          ST_UPPER: if (bitCnt == LAST_BIT) begin
            nBit = 4'd0; nState = ST_LOWER;
          end
          ST_LOWER: if (bitCnt == LAST_BIT) begin
            nBit = 4'd0; nState = moreReg ? ST_UPPER : ST_STOP;
          end
          ST_STOP: begin nBit = 4'd0; nState = ST_IDLE; end
          default: nState = ST_IDLE;
        endcase
      end
    end
    isBit = (nState == ST_ADDR) || (nState == ST_UPPER) || (nState == ST_LOWER);
    if (state != ST_IDLE && tick) begin
      case (nPhase)
        2'd0: begin
          if (isBit) begin
            stb.sclSet = 1'b1;
            stb.sclLow = 1'b1;
            if (nBit != LAST_BIT) begin
              stb.sdaAct = (nState == ST_ADDR) ? SDA_ADDR : SDA_REL;
            end else if (nState == ST_ADDR) begin
              stb.sdaAct = SDA_REL;
            end else if (nState == ST_UPPER) begin
              stb.sdaAct = SDA_LOW;
            end else begin
              decideMore = 1'b1;
              moreVal    = streamReg && !(haltPend || haltReq);
              stb.sdaAct = moreVal ? SDA_LOW : SDA_REL;
            end
          end else if (nState == ST_STOP) begin
            stb.sclSet  = 1'b1;
            stb.sclLow  = 1'b1;
            stb.sdaAct  = SDA_LOW;
            stb.framing = 1'b1;
          end
        end
        2'd2: begin
          if (isBit || nState == ST_STOP) begin
            stb.sclSet = 1'b1;
            stb.sclLow = 1'b0;
          end
          if (nState == ST_START) begin
            stb.sdaAct  = SDA_LOW;
            stb.framing = 1'b1;
          end
        end
        2'd3: begin
          if (isBit) begin
            stb.sample  = 1'b1;
            stb.shiftIn = (nBit != LAST_BIT) && (nState != ST_ADDR);
            stb.emit    = (nState == ST_LOWER) && (nBit == 4'd7);
          end else if (nState == ST_STOP) begin
            stb.sdaAct  = SDA_REL;
            stb.framing = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign stb.bitIdx = nBit[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= 2'd0;
      bitCnt    <= 4'd0;
      divCnt    <= '0;
      streamReg <= 1'b0;
      haltPend  <= 1'b0;
      moreReg   <= 1'b0;
      errReg    <= 1'b0;
    end else begin
      state <= nState;
      if (state == ST_IDLE) begin
        phase  <= 2'd0;
        bitCnt <= 4'd0;
        divCnt <= '0;
        if (startReq) begin
          streamReg <= streamMode;
          haltPend  <= 1'b0;
          errReg    <= 1'b0;
        end
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          phase  <= nPhase;
          bitCnt <= nBit;
        end
        if (haltReq) haltPend <= 1'b1;
        if (setErr) errReg <= 1'b1;
        if (decideMore) moreReg <= moreVal;
      end
    end
  end

  // R2: a missing address acknowledge leads straight to STOP
  p_nak_to_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errReg) |-> (state == ST_STOP));

  // R6: returning from the lower byte to a new upper byte only when streaming
  p_loop_needs_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UPPER && $past(state) == ST_LOWER) |-> streamReg);

  // R1: each byte spans eight data clocks plus one acknowledge clock
  p_bit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= LAST_BIT);

endmodule

// File: rtl/adc_stream_reader.sv
module adc_stream_reader
  import adc_rd_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int SCL_HZ = 400_000,
  parameter int RES_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic             streamMode,
  input  logic             haltReq,
  input  logic [2:0]       devSel,
  input  logic             sdaIn,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic [RES_W-1:0] result,
  output logic             resultValid,
  output logic             ackError,
  output logic             busy
);

  localparam int QTR_RAW = CLK_HZ / (4 * SCL_HZ);
  localparam int QTR     = (QTR_RAW < 1) ? 1 : QTR_RAW;

  strobe_t stb;
  logic    rxBit;

  adc_rd_control #(.QTR(QTR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .streamMode(streamMode),
    .haltReq(haltReq), .rxBit(rxBit), .stb(stb), .busy(busy), .ackError(ackError)
  );

  adc_rd_datapath #(.RES_W(RES_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .devSel(devSel), .sdaIn(sdaIn),
    .rxBit(rxBit), .sclLowReg(sclDriveLow), .sdaLowReg(sdaDriveLow),
    .result(result), .resultValid(resultValid)
  );

  // R9: nothing pulls the bus while idle
  p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclDriveLow && !sdaDriveLow && !resultValid));

endmodule

// File: tb/adc_stream_reader_test.sv
module adc_stream_reader_test;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 4_800_000;
  localparam int SCL_HZ = 400_000;
  localparam int QTR = CLK_HZ / (4 * SCL_HZ);
  localparam int NVEC = 6;
  localparam logic [14:0] VEC [NVEC] = '{
    {3'd0, 12'h000}, {3'd7, 12'hFFF}, {3'd5, 12'hA5C},
    {3'd2, 12'h5A3}, {3'd1, 12'h801}, {3'd6, 12'h07E}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic startReq = 1'b0, streamMode = 1'b0, haltReq = 1'b0;
  logic [2:0] devSel = 3'd0;
  logic sclDriveLow, sdaDriveLow, resultValid, ackError, busy;
  logic [11:0] result;
  logic slaveLow = 1'b0;
  logic sclBus, sdaBus;

  assign sclBus = ~sclDriveLow;
  assign sdaBus = ~(sdaDriveLow | slaveLow);

  adc_stream_reader #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .streamMode(streamMode),
    .haltReq(haltReq), .devSel(devSel), .sdaIn(sdaBus),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .result(result),
    .resultValid(resultValid), .ackError(ackError), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nCmp = 0, nMis = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int got, input int exp);
    nCmp++;
    if (got !== exp) begin
      nMis++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nMis);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nCmp++; nMis++;
    $display("FAIL watchdog got=hung expected=done");
    finishRun();
  end

  // bus event monitor, sampled away from the active edge
  int startCnt = 0, stopCnt = 0;
  logic prevScl = 1'b1, prevSda = 1'b1;
  always @(negedge clk) begin
    if (prevScl && sclBus && prevSda && !sdaBus) startCnt++;
    if (prevScl && sclBus && !prevSda && sdaBus) stopCnt++;
    prevScl <= sclBus;
    prevSda <= sdaBus;
  end

  // result monitor
  int gotCnt = 0;
  logic [11:0] gotVal [4];
  int gotTime [4];
  always @(negedge clk) if (resultValid) begin
    if (gotCnt < 4) begin gotVal[gotCnt] = result; gotTime[gotCnt] = cyc; end
    gotCnt++;
  end

  // slave model
  logic slaveAckEn = 1'b1;
  logic [11:0] slaveVals [4];
  int slaveIdx = 0;
  logic [7:0] addrSeen = '0;
  logic hiAck = 1'b1;
  logic loAcks [4];
  int loAckCnt = 0;

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      slaveLow = ~b[i];
      @(negedge sclBus);
    end
    slaveLow = 1'b0;
    @(posedge sclBus);
    ack = sdaBus;
    @(negedge sclBus);
  endtask

  initial begin
    logic more, a;
    logic [11:0] w;
    forever begin
      @(negedge sdaBus iff sclBus === 1'b1);
      for (int i = 0; i < 8; i++) begin
        @(posedge sclBus);
        addrSeen = {addrSeen[6:0], sdaBus};
      end
      @(negedge sclBus);
      slaveLow = slaveAckEn;
      @(negedge sclBus);
      slaveLow = 1'b0;
      if (slaveAckEn) begin
        more = 1'b1;
        while (more) begin
          w = slaveVals[slaveIdx % 4];
          slaveIdx++;
          sendByte({4'b0000, w[11:8]}, a);
          hiAck = a;
          sendByte(w[7:0], a);
          if (loAckCnt < 4) loAcks[loAckCnt] = a;
          loAckCnt++;
          if (a) more = 1'b0;
        end
      end
    end
  end

  task automatic clearLogs();
    gotCnt = 0; slaveIdx = 0; loAckCnt = 0; hiAck = 1'b1;
    startCnt = 0; stopCnt = 0; addrSeen = '0;
  endtask

  task automatic runTxn(input logic strm);
    @(negedge clk);
    streamMode = strm;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 scl idle", sclDriveLow, 0);
    chk("R9 sda idle", sdaDriveLow, 0);
    chk("R9 busy", busy, 0);
    chk("R9 valid", resultValid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 after reset busy", busy, 0);
    chk("R10 error clear at reset", ackError, 0);

    // table of single reads
    for (int v = 0; v < NVEC; v++) begin
      clearLogs();
      devSel = VEC[v][14:12];
      slaveVals[0] = VEC[v][11:0];
      runTxn(1'b0);
      chk("R1 address byte", addrSeen, {4'b1001, VEC[v][14:12], 1'b1});
      chk("R4 one valid", gotCnt, 1);
      chk("R3 upper nibble", gotVal[0][11:8], VEC[v][11:8]);
      chk("R4 lower byte", gotVal[0][7:0], VEC[v][7:0]);
      chk("R3 upper ack low", hiAck, 0);
      chk("R5 lower NAK", loAcks[0], 1);
      chk("R8 one START", startCnt, 1);
      chk("R5 one STOP", stopCnt, 1);
      chk("R5 idle after", busy, 0);
      chk("R2 no error", ackError, 0);
      chk("R9 lines released", {sclDriveLow, sdaDriveLow}, 0);
    end

    // streaming with halt after the second result
    clearLogs();
    devSel = 3'd3;
    slaveVals[0] = 12'h123; slaveVals[1] = 12'hEDC; slaveVals[2] = 12'h3C3;
    @(negedge clk);
    streamMode = 1'b1;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (gotCnt < 2) @(negedge clk);
    haltReq = 1'b1;
    while (busy) @(negedge clk);
    haltReq = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 address", addrSeen, 8'b1001_0111);
    chk("R7 two results", gotCnt, 2);
    chk("R6 first value", gotVal[0], 12'h123);
    chk("R6 second value", gotVal[1], 12'hEDC);
    chk("R6 spacing", gotTime[1] - gotTime[0], 72 * QTR);
    chk("R6 no repeat START", startCnt, 1);
    chk("R6 lower ACK kept", loAcks[0], 0);
    chk("R7 lower NAK at halt", loAcks[1], 1);
    chk("R7 STOP", stopCnt, 1);
    chk("R7 idle", busy, 0);

    // address not acknowledged
    clearLogs();
    slaveAckEn = 1'b0;
    devSel = 3'd4;
    runTxn(1'b0);
    chk("R2 error set", ackError, 1);
    chk("R2 no result", gotCnt, 0);
    chk("R2 STOP", stopCnt, 1);
    chk("R2 idle", busy, 0);
    repeat (20) @(negedge clk);
    chk("R10 error held", ackError, 1);

    // next start clears error
    clearLogs();
    slaveAckEn = 1'b1;
    slaveVals[0] = 12'h9B6;
    runTxn(1'b0);
    chk("R10 error cleared", ackError, 0);
    chk("R4 value after error", gotVal[0], 12'h9B6);
    chk("R4 valid count", gotCnt, 1);

    finishRun();
  end

endmodule